// File: doc/BRIEF.md
# Video/Control Phase Word Framer

This block turns a parallel pixel interface into one 20-bit line word per clock, ready for a separate shifter that sends each word least significant bit first. Each cycle it samples a data-enable flag, an 18-bit video bus and a 9-bit control bus. While data-enable is high it sends video words. The video symbols may be inverted so that the line stays DC balanced. While data-enable is low it sends control words, in which five of the control bits are repeated three times each so that a receiver can take a majority vote.

Around every change of phase the framer sends a fixed marker word in place of control data. This happens during the two low cycles just before data-enable rises and during the first two low cycles after it falls. To see a rise before it happens, the inputs pass through a short delay line. Each output word carries a valid strobe and a tag for its phase.

Top module: `vcf_word_framer`

## Requirements
- R1: A synchronous reset drives `word_vld` low, `word_out` to zero and `phase_tag` to 0 on the next edge. After reset is released, `word_vld` goes high on the third rising edge and stays high until the next reset.
- R2: The inputs sampled on rising edge k set the output word that appears after edge k+2. The de_in value sampled on edge k+2 also serves as lookahead for that word.
- R3: A video word (de_in high) has bit 0 = 0, bit 1 = the inversion flag, and bits 2..19 = the 18 video bits (bit 2 = vid_in[0]), inverted when the flag is 1.
- R4: The inversion flag is chosen from the running disparity D of all earlier video words and the disparity P of the word sent without inversion (disparity = number of ones minus number of zeros over 20 bits). When D > 0 the flag is (P > 0); otherwise it is (P < 0).
- R5: The running disparity over video words stays within -20..+20.
- R6: A control word has bit 0 = 1, bits 1+3i..3+3i = three copies of ctl_in[i] for i = 0..4, and bits 16..19 = ctl_in[8:5].
- R7: A low de_in cycle that is followed by a high de_in within the next two cycles sends the rising marker 0x0F0F1 with tag 1.
- R8: A low de_in cycle that has a high de_in within the two cycles before it, and no rise within the next two, sends the falling marker 0xF0F0F with tag 1.
- R9: When a low cycle lies within both windows, the rising marker wins. A video word never directly follows a control word, and a control word never directly follows a video word.
- R10: `phase_tag` is 0 for control, 1 for marker and 2 for video. The value 3 never appears.
- R11: Both markers have bit 0 = 1 and at least one mixed bit triplet in bits 1..15, so neither can be a legal video word or control word.
- R12: ctl_in has no effect on the output while de_in is high, and vid_in has no effect while de_in is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| de_in | input | 1 | Data enable: 1 = video, 0 = control |
| vid_in | input | 18 | Video data |
| ctl_in | input | 9 | Control data |
| word_out | output | 20 | Framed line word, bit 0 sent first |
| word_vld | output | 1 | Word valid strobe |
| phase_tag | output | 2 | Phase of the word: 0 control, 1 marker, 2 video |

## Verification
Every word is due after the third register in the path. The input sampled on edge k appears after edge k+2, and its phase choice depends on the de_in values of edges k+1 and k+2 and of edges k-1 and k-2. The reference model records the inputs at each rising edge, builds the word for the input two edges back, and compares it with the output on the following falling edge. Reset clears the outputs one edge after it is sampled and restarts the three-edge fill, and the model resets its history at the same edge. The model keeps its own disparity count to check the inversion choice and the disparity bound.

// File: rtl/vcf_pkg.sv
package vcf_pkg;

    localparam int VID_W  = 18;
    localparam int CTL_W  = 9;
    localparam int TRIP_N = 5;
    localparam int SOLO_N = CTL_W - TRIP_N;
    localparam int WORD_W = VID_W + 2;
    localparam int RD_W   = 6;

    localparam logic [WORD_W-1:0] RISE_WORD = 20'h0F0F1;
    localparam logic [WORD_W-1:0] FALL_WORD = 20'hF0F0F;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {
        PH_CTL = 2'd0,
        PH_TRN = 2'd1,
        PH_VID = 2'd2
    } phase_e;

    typedef struct packed {
        logic             vld;
        logic             de;
        logic [VID_W-1:0] vid;
        logic [CTL_W-1:0] ctl;
    } stage_t;

    function automatic word_t pack_ctl(input logic [CTL_W-1:0] c);
        word_t w;
        w    = '0;
        w[0] = 1'b1;
        for (int i = 0; i < TRIP_N; i++) begin
            w[1+3*i +: 3] = {3{c[i]}};
        end
        for (int i = 0; i < SOLO_N; i++) begin
            w[1+3*TRIP_N+i] = c[TRIP_N+i];
        end
        return w;
    endfunction

    function automatic logic triplets_uniform(input word_t w);
        logic ok;
        ok = 1'b1;
        for (int i = 0; i < TRIP_N; i++) begin
            if (w[1+3*i +: 3] != 3'b000 && w[1+3*i +: 3] != 3'b111) begin
                ok = 1'b0;
            end
        end
        return ok;
    endfunction

endpackage

// File: rtl/vcf_stage_pipe.sv
module vcf_stage_pipe
    import vcf_pkg::*;
#(
    parameter int GUARD = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    de_in,
    input  logic [VID_W-1:0]        vid_in,
    input  logic [CTL_W-1:0]        ctl_in,
    output stage_t [GUARD-1:0]      stg_o
);

    stage_t [GUARD-1:0] stg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stg_q <= '0;
        end else begin
            stg_q[0].vld <= 1'b1;
            stg_q[0].de  <= de_in;
            if (de_in) begin
                stg_q[0].vid <= vid_in;
            end else begin
                stg_q[0].ctl <= ctl_in;
            end
            for (int s = 1; s < GUARD; s++) begin
                stg_q[s] <= stg_q[s-1];
            end
        end
    end

    assign stg_o = stg_q;

endmodule

// File: rtl/vcf_phase_sel.sv
module vcf_phase_sel
    import vcf_pkg::*;
#(
    parameter int GUARD = 2
) (
    input  logic             cur_de,
    input  logic [GUARD-1:0] ahead,
    input  logic [GUARD-1:0] behind,
    output phase_e           phase,
    output logic             rise_side
);

    always_comb begin
        rise_side = 1'b0;
        if (cur_de) begin
            phase = PH_VID;
        end else if (|ahead) begin
            phase     = PH_TRN;
            rise_side = 1'b1;
        end else if (|behind) begin
            phase = PH_TRN;
        end else begin
            phase = PH_CTL;
        end
    end

endmodule

// File: rtl/vcf_bal_enc.sv
module vcf_bal_enc
    import vcf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    input  logic [VID_W-1:0] sym,
    output word_t            vword
);

    logic signed [RD_W-1:0] rd_q;
    int   ones;
    int   d_plain;
    int   d_inv;
    int   rd_n;
    logic inv;

    always_comb begin
        ones    = $countones(sym);
        d_plain = 2 * ones - WORD_W;
        d_inv   = 2 * (VID_W + 1 - ones) - WORD_W;
        if (rd_q > 0) begin
            inv = (d_plain > 0);
        end else begin
            inv = (d_plain < 0);
        end
        vword = {(inv ? ~sym : sym), inv, 1'b0};
        rd_n  = int'(rd_q) + (inv ? d_inv : d_plain);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= '0;
        end else if (adv) begin
            rd_q <= RD_W'(rd_n);
        end
    end

endmodule

// File: rtl/vcf_word_framer.sv
module vcf_word_framer
    import vcf_pkg::*;
#(
    parameter int GUARD = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        de_in,
    input  logic [17:0] vid_in,
    input  logic [8:0]  ctl_in,
    output logic [19:0] word_out,
    output logic        word_vld,
    output logic [1:0]  phase_tag
);

    localparam int OLD = GUARD - 1;

    stage_t [GUARD-1:0] stg;
    logic [GUARD-1:0]   ahead;
    logic [GUARD-1:0]   behind_q;
    phase_e             phase;
    logic               rise_side;
    word_t              vword;
    word_t              word_q;
    logic               vld_q;
    phase_e             tag_q;

    vcf_stage_pipe #(.GUARD(GUARD)) pipe_i (
        .clk    (clk),
        .rst    (rst),
        .de_in  (de_in),
        .vid_in (vid_in),
        .ctl_in (ctl_in),
        .stg_o  (stg)
    );

    // ahead[0] is the next input after the oldest stage, ahead[GUARD-1] the live pin
    generate
        for (genvar a = 0; a < GUARD - 1; a++) begin : g_ahead
            assign ahead[a] = stg[GUARD-2-a].de;
        end
    endgenerate
    assign ahead[GUARD-1] = de_in;

    vcf_phase_sel #(.GUARD(GUARD)) sel_i (
        .cur_de    (stg[OLD].de),
        .ahead     (ahead),
        .behind    (behind_q),
        .phase     (phase),
        .rise_side (rise_side)
    );

    vcf_bal_enc enc_i (
        .clk   (clk),
        .rst   (rst),
        .adv   (stg[OLD].vld && (phase == PH_VID)),
        .sym   (stg[OLD].vid),
        .vword (vword)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q   <= '0;
            vld_q    <= 1'b0;
            tag_q    <= PH_CTL;
            behind_q <= '0;
        end else begin
            vld_q <= stg[OLD].vld;
            if (stg[OLD].vld) begin
                if (GUARD > 1) begin
                    behind_q <= {behind_q[GUARD-2:0], stg[OLD].de};
                end else begin
                    behind_q <= stg[OLD].de;
                end
                tag_q <= phase;
                unique case (phase)
                    PH_VID:  word_q <= vword;
                    PH_TRN:  word_q <= rise_side ? RISE_WORD : FALL_WORD;
                    default: word_q <= pack_ctl(stg[OLD].ctl);
                endcase
            end else begin
                word_q <= '0;
                tag_q  <= PH_CTL;
            end
        end
    end

    assign word_out  = word_q;
    assign word_vld  = vld_q;
    assign phase_tag = tag_q;

endmodule

// File: rtl/vcf_word_framer_chk.sv
module vcf_word_framer_chk
    import vcf_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic [19:0] word_out,
    input logic        word_vld,
    input logic [1:0]  phase_tag
);

    int rd_c;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_c <= 0;
        end else if (word_vld && phase_tag == PH_VID) begin
            rd_c <= rd_c + 2 * $countones(word_out) - WORD_W;
        end
    end

    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (!word_vld && word_out == '0 && phase_tag == 2'd0));

    assert_valid_holds_R1: assert property (@(posedge clk) disable iff (rst)
        word_vld |=> word_vld);

    assert_tag_legal_R10: assert property (@(posedge clk) disable iff (rst)
        word_vld |-> (phase_tag != 2'd3));

    assert_video_en0_R3: assert property (@(posedge clk) disable iff (rst)
        (word_vld && phase_tag == PH_VID) |-> (word_out[0] == 1'b0));

    assert_ctl_layout_R6: assert property (@(posedge clk) disable iff (rst)
        (word_vld && phase_tag == PH_CTL) |-> (word_out[0] && triplets_uniform(word_out)));

    assert_marker_value_R11: assert property (@(posedge clk) disable iff (rst)
        (word_vld && phase_tag == PH_TRN) |-> (word_out == RISE_WORD || word_out == FALL_WORD));

    assert_rise_then_video_R7: assert property (@(posedge clk) disable iff (rst)
        (word_vld && phase_tag == PH_TRN && word_out == RISE_WORD) |=>
        (phase_tag == PH_VID || (phase_tag == PH_TRN && word_out == RISE_WORD)));

    assert_no_ctl_to_vid_R9: assert property (@(posedge clk) disable iff (rst)
        (word_vld && phase_tag == PH_CTL) |=> (phase_tag != PH_VID));

    assert_no_vid_to_ctl_R8: assert property (@(posedge clk) disable iff (rst)
        (word_vld && phase_tag == PH_VID) |=> (phase_tag != PH_CTL));

    assert_disparity_bound_R5: assert property (@(posedge clk) disable iff (rst)
        (rd_c >= -20 && rd_c <= 20));

endmodule

bind vcf_word_framer vcf_word_framer_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .word_out  (word_out),
    .word_vld  (word_vld),
    .phase_tag (phase_tag)
);

// File: tb/vcf_word_framer_tb_top.sv
module vcf_word_framer_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;
    localparam logic [19:0] RISE_M = 20'h0F0F1;
    localparam logic [19:0] FALL_M = 20'hF0F0F;

    logic        clk = 1'b0;
    logic        rst;
    logic        de_in;
    logic [17:0] vid_in;
    logic [8:0]  ctl_in;
    logic [19:0] word_out;
    logic        word_vld;
    logic [1:0]  phase_tag;

    int total = 0;
    int bad   = 0;
    int cycles = 0;
    bit done = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    vcf_word_framer dut_i (
        .clk       (clk),
        .rst       (rst),
        .de_in     (de_in),
        .vid_in    (vid_in),
        .ctl_in    (ctl_in),
        .word_out  (word_out),
        .word_vld  (word_vld),
        .phase_tag (phase_tag)
    );

    // reference model state
    bit          de_h[$];
    logic [17:0] vid_h[$];
    logic [8:0]  ctl_h[$];
    int          rd_m;
    logic [19:0] exp_word;
    logic        exp_vld;
    logic [1:0]  exp_tag;
    string       exp_req;

    function automatic bit de_at(int x);
        if (x < 0) return 1'b0;
        return de_h[x];
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            de_h.delete();
            vid_h.delete();
            ctl_h.delete();
            rd_m     = 0;
            exp_vld  = 1'b0;
            exp_word = '0;
            exp_tag  = 2'd0;
            exp_req  = "R1";
        end else begin
            int i;
            de_h.push_back(de_in);
            vid_h.push_back(vid_in);
            ctl_h.push_back(ctl_in);
            i = de_h.size() - 1;
            if (i < 2) begin
                exp_vld  = 1'b0;
                exp_word = '0;
                exp_tag  = 2'd0;
                exp_req  = "R1";
            end else begin
                int  j;
                bit  pre;
                bit  post;
                j    = i - 2;
                pre  = de_at(j + 1) | de_at(j + 2);
                post = de_at(j - 1) | de_at(j - 2);
                exp_vld = 1'b1;
                if (de_at(j)) begin
                    int ones;
                    int p;
                    bit inv;
                    ones = $countones(vid_h[j]);
                    p    = 2 * ones - 20;
                    inv  = (rd_m > 0) ? (p > 0) : (p < 0);
                    exp_word = {(inv ? ~vid_h[j] : vid_h[j]), inv, 1'b0};
                    rd_m     = rd_m + 2 * $countones(exp_word) - 20;
                    exp_tag  = 2'd2;
                    exp_req  = "R3 R4 R12";
                end else if (pre) begin
                    exp_word = RISE_M;
                    exp_tag  = 2'd1;
                    exp_req  = post ? "R9" : "R7";
                end else if (post) begin
                    exp_word = FALL_M;
                    exp_tag  = 2'd1;
                    exp_req  = "R8";
                end else begin
                    logic [8:0] c;
                    c = ctl_h[j];
                    exp_word = {c[8:5], {3{c[4]}}, {3{c[3]}}, {3{c[2]}},
                                {3{c[1]}}, {3{c[0]}}, 1'b1};
                    exp_tag  = 2'd0;
                    exp_req  = "R6 R12";
                end
            end
        end
        if (cycles > WATCHDOG && !done) begin
            bad++;
            total++;
            $display("FAIL watchdog: run hung, actual=%0d cycles expected<=%0d", cycles, WATCHDOG);
            finish_run();
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, expv, $time);
        end
    endtask

    task automatic finish_run();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // compare away from the active edge
    always @(negedge clk) begin
        if (cycles > 0 && !done) begin
            check(word_vld === exp_vld, "R1 R2 valid", 32'(word_vld), 32'(exp_vld));
            if (exp_vld) begin
                check(word_out === exp_word, exp_req, 32'(word_out), 32'(exp_word));
                check(phase_tag === exp_tag, "R10", 32'(phase_tag), 32'(exp_tag));
                if (exp_tag == 2'd2) begin
                    check(rd_m >= -20 && rd_m <= 20, "R5", 32'(rd_m), 32'd20);
                end
                if (exp_tag == 2'd1) begin
                    bit mixed;
                    mixed = 1'b0;
                    for (int t = 0; t < 5; t++) begin
                        if (word_out[1+3*t +: 3] != 3'b000 && word_out[1+3*t +: 3] != 3'b111) mixed = 1'b1;
                    end
                    check(word_out[0] && mixed, "R11", 32'(word_out), 32'(exp_word));
                end
            end else begin
                check(word_out === '0 && phase_tag === 2'd0, "R1 idle", 32'(word_out), 32'd0);
            end
        end
    end

    task automatic drive(input bit d, input logic [17:0] v, input logic [8:0] c);
        de_in  = d;
        vid_in = v;
        ctl_in = c;
        @(negedge clk);
    endtask

    task automatic run(input bit d, input int n);
        for (int k = 0; k < n; k++) begin
            drive(d, 18'($urandom), 9'($urandom));
        end
    endtask

    initial begin
        rst    = 1'b1;
        de_in  = 1'b0;
        vid_in = '0;
        ctl_in = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // long control phase, then fixed video patterns
        run(0, 8);
        drive(1, 18'h00000, 9'h1AA);
        drive(1, 18'h3FFFF, 9'h155);
        drive(1, 18'h3FF00, 9'h0F0);
        drive(1, 18'h00000, 9'h10F);
        drive(1, 18'h3FFFF, 9'h0FF);
        run(1, 3);
        drive(0, 18'h2AAAA, 9'h1FF);
        drive(0, 18'h15555, 9'h000);
        drive(0, 18'h3FFFF, 9'h155);
        run(0, 5);
        // control gaps of every short length
        for (int g = 1; g <= 6; g++) begin
            run(1, 3);
            run(0, g);
        end
        // single-cycle video bursts
        for (int b = 0; b < 4; b++) begin
            run(1, 1);
            run(0, 3);
        end
        // random phases
        for (int k = 0; k < 300; k++) begin
            drive(($urandom % 3) != 0, 18'($urandom), 9'($urandom));
        end
        // reset in mid stream
        rst = 1'b1;
        run(1, 2);
        rst = 1'b0;
        run(1, 4);
        run(0, 12);
        for (int k = 0; k < 150; k++) begin
            drive(($urandom % 5) < 2, 18'($urandom), 9'($urandom));
        end
        run(0, 6);
        finish_run();
    end

endmodule